// File: doc/BRIEF.md
# Cache Line Burst Chunk Sequencer

This block turns one transfer request into the series of 8-byte chunk addresses and byte-lane enables that cross a 64-bit data bus, one chunk per data clock. A request gives the upper bits of a 36-bit physical address (bits 35:3), a transfer kind and a byte-enable vector. The kind is a whole 32-byte line, a 16-byte half line, or a partial access of 0 to 8 bytes inside one aligned 8-byte span.

Chunks go out in an interleaved order. The chunk that was asked for goes first. Each later chunk index is the starting index XORed with the beat number. The order is the same whether the data moves in or out. The request side uses a valid/ready handshake. The beat side gives a valid flag, a last flag and the beat number, and it can be stalled by a downstream ready. A new request can be taken in the same cycle as the final beat of the current one, so bursts run back to back with no gap.

Top module: `burst_chunk_seq`

## Requirements
- R1: A line request (kind 2'b00) produces four beats. The chunk index on beat k is start XOR k, where start is request address bit pair [4:3]. Starts 0, 1, 2 and 3 give offsets 0,8,10,18 / 8,0,18,10 / 10,18,0,8 / 18,10,8,0 (hex).
- R2: Beat 0 of every request carries the requested chunk index, unchanged, for every kind.
- R3: A half-line request (kind 2'b01) produces two beats, start then start XOR 1. Both chunks stay inside the same 16-byte half and the same line.
- R4: On every beat of a line or half-line request, all 8 byte enables are 1.
- R5: A partial request (kind 2'b10 or 2'b11) produces exactly one beat whose byte enables equal the requested vector, including 8'h00.
- R6: Beat address bits [32:2] (physical bits 35:5) equal the request's, and bits [1:0] (physical bits 4:3) hold the sequenced chunk index.
- R7: The last flag is 1 only on the final beat: beat 3 for a line, beat 1 for a half line, beat 0 for a partial access.
- R8: After reset, beat valid is 0 and request ready is 1. Request ready is 1 only when no beat is pending, or when the final beat completes in that cycle. In the second case, the next request's first beat follows in the very next cycle.
- R9: While beat valid is 1 and beat ready is 0, beat valid, address, byte enables, last flag and beat number stay unchanged. Sequencing advances only on cycles where valid and ready are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Request accepted when high together with req_valid_i |
| req_addr_i | input | 33 | Physical address bits 35:3 |
| req_kind_i | input | 2 | 00 line, 01 half line, 1x partial |
| req_be_i | input | 8 | Byte enables for a partial access |
| beat_valid_o | output | 1 | A beat is presented |
| beat_ready_i | input | 1 | Downstream takes the beat |
| beat_addr_o | output | 33 | Chunk address, physical bits 35:3 |
| beat_be_o | output | 8 | Byte-lane enables of the beat |
| beat_last_o | output | 1 | Final beat of the request |
| beat_num_o | output | 2 | Beat number within the request |

## Verification
The bench builds the block with its default parameters: a 36-bit address, 8-byte chunks and 4-chunk lines. These values bring every start index of both line and half-line bursts within reach, along with the full 8-lane enable path. Downstream ready is first held high and then driven from a pseudo-random sequence. This covers stalls on every beat position and requests that arrive while the final beat is stalled, as well as back-to-back acceptance and zero-byte partial accesses.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  typedef enum logic [1:0] {
    XK_LINE = 2'b00,
    XK_HALF = 2'b01,
    XK_PART = 2'b10,
    XK_PRT2 = 2'b11
  } xfer_kind_e;

  function automatic logic is_partial(input logic [1:0] kind);
    return kind[1];
  endfunction

  function automatic logic is_half(input logic [1:0] kind);
    return (kind == XK_HALF);
  endfunction
endpackage

// File: rtl/chunk_order_gen.sv
module chunk_order_gen #(
  parameter int IDX_W = 2
) (
  input  logic [IDX_W-1:0] start_i,
  input  logic [IDX_W-1:0] beat_i,
  output logic [IDX_W-1:0] idx_o
);
  // interleaved order: each index bit toggles with the matching beat bit
  for (genvar b = 0; b < IDX_W; b++) begin : g_bit
    assign idx_o[b] = start_i[b] ^ beat_i[b];
  end
endmodule

// File: rtl/lane_enable_gen.sv
module lane_enable_gen #(
  parameter int LANES = 8
) (
  input  logic             full_i,
  input  logic [LANES-1:0] be_i,
  output logic [LANES-1:0] be_o
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign be_o[l] = full_i | be_i[l];
  end
endmodule

// File: rtl/beat_ctrl.sv
module beat_ctrl
  import burst_seq_pkg::*;
#(
  parameter int LINE_CHUNKS = 4,
  localparam int IDX_W = $clog2(LINE_CHUNKS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic [1:0]       req_kind_i,
  input  logic             beat_ready_i,
  output logic             req_ready_o,
  output logic             req_fire_o,
  output logic             busy_o,
  output logic [IDX_W-1:0] cnt_o,
  output logic             last_o
);
  localparam logic [IDX_W-1:0] LAST_LINE = IDX_W'(LINE_CHUNKS - 1);
  localparam logic [IDX_W-1:0] LAST_HALF = IDX_W'(LINE_CHUNKS / 2 - 1);

  logic             busy_q;
  logic [IDX_W-1:0] cnt_q;
  logic [1:0]       kind_q;
  logic [IDX_W-1:0] last_idx;
  logic             beat_fire;

  always_comb begin
    if (is_partial(kind_q))   last_idx = '0;
    else if (is_half(kind_q)) last_idx = LAST_HALF;
    else                      last_idx = LAST_LINE;
  end

  assign last_o      = busy_q && (cnt_q == last_idx);
  assign beat_fire   = busy_q && beat_ready_i;
  assign req_ready_o = !busy_q || (beat_fire && last_o);
  assign req_fire_o  = req_valid_i && req_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      kind_q <= XK_LINE;
    end else if (req_fire_o) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
      kind_q <= req_kind_i;
    end else if (beat_fire) begin
      if (last_o) begin
        busy_q <= 1'b0;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign busy_o = busy_q;
  assign cnt_o  = cnt_q;
endmodule

// File: rtl/burst_chunk_seq.sv
module burst_chunk_seq
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W      = 36,
  parameter int CHUNK_BYTES = 8,
  parameter int LINE_CHUNKS = 4,
  localparam int OFF_W  = $clog2(CHUNK_BYTES),
  localparam int IDX_W  = $clog2(LINE_CHUNKS),
  localparam int BUS_AW = ADDR_W - OFF_W
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   req_valid_i,
  output logic                   req_ready_o,
  input  logic [BUS_AW-1:0]      req_addr_i,
  input  logic [1:0]             req_kind_i,
  input  logic [CHUNK_BYTES-1:0] req_be_i,
  output logic                   beat_valid_o,
  input  logic                   beat_ready_i,
  output logic [BUS_AW-1:0]      beat_addr_o,
  output logic [CHUNK_BYTES-1:0] beat_be_o,
  output logic                   beat_last_o,
  output logic [IDX_W-1:0]       beat_num_o
);
  logic                   req_fire;
  logic                   busy;
  logic [IDX_W-1:0]       cnt;
  logic                   last;
  logic [BUS_AW-1:0]      addr_q;
  logic                   full_q;
  logic [CHUNK_BYTES-1:0] be_q;
  logic [IDX_W-1:0]       chunk_idx;

  beat_ctrl #(.LINE_CHUNKS(LINE_CHUNKS)) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .req_valid_i  (req_valid_i),
    .req_kind_i   (req_kind_i),
    .beat_ready_i (beat_ready_i),
    .req_ready_o  (req_ready_o),
    .req_fire_o   (req_fire),
    .busy_o       (busy),
    .cnt_o        (cnt),
    .last_o       (last)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      full_q <= 1'b0;
      be_q   <= '0;
    end else if (req_fire) begin
      addr_q <= req_addr_i;
      full_q <= !is_partial(req_kind_i);
      be_q   <= req_be_i;
    end
  end

  chunk_order_gen #(.IDX_W(IDX_W)) u_order (
    .start_i (addr_q[IDX_W-1:0]),
    .beat_i  (cnt),
    .idx_o   (chunk_idx)
  );

  lane_enable_gen #(.LANES(CHUNK_BYTES)) u_lanes (
    .full_i (full_q),
    .be_i   (be_q),
    .be_o   (beat_be_o)
  );

  assign beat_valid_o = busy;
  assign beat_addr_o  = {addr_q[BUS_AW-1:IDX_W], chunk_idx};
  assign beat_last_o  = last;
  assign beat_num_o   = cnt;
endmodule

// File: rtl/burst_chunk_seq_chk.sv
module burst_chunk_seq_chk #(
  parameter int BUS_AW = 33,
  parameter int LANES  = 8,
  parameter int IDX_W  = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_ready_o,
  input logic              beat_valid_o,
  input logic              beat_ready_i,
  input logic [BUS_AW-1:0] beat_addr_o,
  input logic [LANES-1:0]  beat_be_o,
  input logic              beat_last_o,
  input logic [IDX_W-1:0]  beat_num_o
);
  AST_STALL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    beat_valid_o && !beat_ready_i |=> beat_valid_o && $stable(beat_addr_o)
      && $stable(beat_be_o) && $stable(beat_last_o) && $stable(beat_num_o)); // R9
  AST_UPPER_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    beat_valid_o && beat_ready_i && !beat_last_o |=> beat_valid_o
      && (beat_addr_o[BUS_AW-1:IDX_W] == $past(beat_addr_o[BUS_AW-1:IDX_W]))); // R6
  AST_XOR_ORDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    beat_valid_o && beat_ready_i && !beat_last_o |=>
      ((beat_addr_o[IDX_W-1:0] ^ beat_num_o)
        == ($past(beat_addr_o[IDX_W-1:0]) ^ $past(beat_num_o)))); // R1
  AST_BEAT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    beat_valid_o && beat_ready_i && !beat_last_o |=>
      beat_num_o == $past(beat_num_o) + 1'b1); // R7
  AST_FULL_LANES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    beat_valid_o && !beat_last_o |-> beat_be_o == {LANES{1'b1}}); // R4
  AST_NO_EARLY_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    beat_valid_o && !(beat_ready_i && beat_last_o) |-> !req_ready_o); // R8
  AST_IDLE_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !beat_valid_o |-> req_ready_o); // R8
endmodule

bind burst_chunk_seq burst_chunk_seq_chk #(
  .BUS_AW (BUS_AW),
  .LANES  (CHUNK_BYTES),
  .IDX_W  (IDX_W)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_ready_o  (req_ready_o),
  .beat_valid_o (beat_valid_o),
  .beat_ready_i (beat_ready_i),
  .beat_addr_o  (beat_addr_o),
  .beat_be_o    (beat_be_o),
  .beat_last_o  (beat_last_o),
  .beat_num_o   (beat_num_o)
);

// File: tb/sim_burst_chunk_seq.sv
`timescale 1ns/1ps
module sim_burst_chunk_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [32:0] req_addr = '0;
  logic [1:0]  req_kind = 2'b00;
  logic [7:0]  req_be = '0;
  logic        beat_valid;
  logic        beat_ready = 1'b1;
  logic [32:0] beat_addr;
  logic [7:0]  beat_be;
  logic        beat_last;
  logic [1:0]  beat_num;

  typedef struct {
    logic [32:0] a;
    logic [7:0]  be;
    logic        last;
    logic [1:0]  num;
    string       tag;
  } exp_t;
  exp_t exp_q[$];

  int checks = 0;
  int errors = 0;
  bit rnd_ready = 1'b0;
  logic [15:0] lfsr = 16'hACE1;
  int cycles = 0;

  always #2.5 clk = ~clk;

  burst_chunk_seq u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_addr_i(req_addr), .req_kind_i(req_kind), .req_be_i(req_be),
    .beat_valid_o(beat_valid), .beat_ready_i(beat_ready), .beat_addr_o(beat_addr),
    .beat_be_o(beat_be), .beat_last_o(beat_last), .beat_num_o(beat_num)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  // byte offset of the k-th chunk, written from the ordering table
  function automatic logic [4:0] order_off(input logic [1:0] s, input int k);
    logic [4:0] t [4][4];
    t[0] = '{5'h00, 5'h08, 5'h10, 5'h18};
    t[1] = '{5'h08, 5'h00, 5'h18, 5'h10};
    t[2] = '{5'h10, 5'h18, 5'h00, 5'h08};
    t[3] = '{5'h18, 5'h10, 5'h08, 5'h00};
    return t[s][k];
  endfunction

  task automatic send(input logic [32:0] a, input logic [1:0] kind, input logic [7:0] be,
                      input string tag);
    int n;
    n = kind[1] ? 1 : (kind == 2'b01 ? 2 : 4);
    for (int k = 0; k < n; k++) begin
      exp_t e;
      logic [4:0] off;
      off    = order_off(a[1:0], k);
      e.a    = {a[32:2], off[4:3]};
      e.be   = kind[1] ? be : 8'hFF;
      e.last = (k == n - 1);
      e.num  = 2'(k);
      e.tag  = tag;
      exp_q.push_back(e);
    end
    req_valid = 1'b1; req_addr = a; req_kind = kind; req_be = be;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  // ready driver
  always @(posedge clk) begin
    #1;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    beat_ready = rnd_ready ? lfsr[0] : 1'b1;
  end

  // monitor
  bit          stall_seen = 1'b0;
  bit          b2b_pend = 1'b0;
  logic [32:0] s_a;
  logic [7:0]  s_be;
  logic        s_last;
  always @(negedge clk) begin
    if (rst_n) begin
      if (b2b_pend) begin
        chk(beat_valid == 1'b1, "R8", "back-to-back first beat valid", beat_valid, 1);
        b2b_pend = 1'b0;
      end
      if (stall_seen) begin
        chk(beat_valid && beat_addr == s_a && beat_be == s_be && beat_last == s_last,
            "R9", "stalled beat changed", {beat_valid, beat_addr}, {1'b1, s_a});
        stall_seen = 1'b0;
      end
      if (beat_valid && !(beat_ready && beat_last))
        chk(req_ready == 1'b0, "R8", "ready while beat pending", req_ready, 0);
      if (beat_valid && !beat_ready) begin
        stall_seen = 1'b1; s_a = beat_addr; s_be = beat_be; s_last = beat_last;
      end
      if (beat_valid && beat_ready) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R7", "unexpected beat", beat_addr, 0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          chk(beat_addr == e.a, "R1 R2 R3 R6", {e.tag, " addr"}, beat_addr, e.a);
          chk(beat_be == e.be, "R4 R5", {e.tag, " be"}, beat_be, e.be);
          chk(beat_last == e.last, "R7", {e.tag, " last"}, beat_last, e.last);
          chk(beat_num == e.num, "R7", {e.tag, " beat num"}, beat_num, e.num);
        end
        if (beat_last && req_valid) b2b_pend = 1'b1;
      end
    end
  end

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #1;
    chk(beat_valid == 1'b0, "R8", "reset beat valid", beat_valid, 0);
    chk(req_ready == 1'b1, "R8", "reset req ready", req_ready, 1);
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;
    // R1 R2: line bursts at every start chunk, ready held high
    for (int s = 0; s < 4; s++) send({31'h5A5A_1234, 2'(s)}, 2'b00, 8'h00, "R1 line");
    // R3: half-line bursts at every start
    for (int s = 0; s < 4; s++) send({31'h0123_4567, 2'(s)}, 2'b01, 8'h3C, "R3 half");
    // R5: partial, pattern, zero bytes, alternate code
    send(33'h1_2345_6789, 2'b10, 8'hA5, "R5 partial");
    send(33'h0_FFFF_FFFE, 2'b10, 8'h00, "R5 zero-byte partial");
    send(33'h1_0000_0003, 2'b11, 8'h81, "R5 partial kind 11");
    // R6: top address bits all ones
    send(33'h1_FFFF_FFFD, 2'b00, 8'h00, "R6 upper bits");
    repeat (8) @(posedge clk); #1;
    chk(exp_q.size() == 0, "R7", "beats outstanding after directed", exp_q.size(), 0);
    // R9 R8: random stalls with mixed kinds, back to back
    rnd_ready = 1'b1;
    for (int i = 0; i < 60; i++) begin
      logic [32:0] a;
      a = {lfsr, lfsr[12:0], lfsr[3:0]} ^ 33'(i * 32'h9E37_79B9);
      send(a, 2'(i % 4), lfsr[7:0] ^ 8'(i), "R9 mixed");
    end
    rnd_ready = 1'b0;
    repeat (20) @(posedge clk); #1;
    chk(exp_q.size() == 0, "R7", "beats outstanding at end", exp_q.size(), 0);
    chk(beat_valid == 1'b0 && req_ready == 1'b1, "R8", "idle at end",
        {beat_valid, req_ready}, 2'b01);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule